// File: doc/BRIEF.md
# Frame Phase Measurement Counter

This block measures where, inside the local 2.048 Mbit/s TDM bus frame, the recovered T1 receive frame begins. The local frame has 32 channels of 8 bits, so one frame spans 256 bit clocks and 125 µs. A local position counter runs on the local bit clock. The local frame pulse realigns it. Each rising edge of the 8 kHz receive frame marker takes a snapshot of that counter.

The marker comes from the receive clock domain. It passes through a two-stage synchroniser before its rising edge is detected. The captured position is reported as an 8-bit phase word. Its upper five bits are the channel number and its lower three bits are the bit number within that channel.

A ninth bit, the frame-count bit, extends the reading across frame boundaries. Each new capture is compared with the one before it. When the two differ by more than half a frame, the reading has crossed the frame boundary and the ninth bit toggles. This works in either direction, so a slowly drifting offset can be tracked without ambiguity.

Top module: `frame_phase_meter`

## Requirements
- R1: While reset is active, and in the cycles after reset until the first capture, phaseWord is 0, frameCount is 0 and phaseValid is 0.
- R2: The local position counter becomes 0 on the clock edge at which framePulse is sampled high. It then advances by one on each later edge.
- R3: phaseWord[7:3] holds the channel (0 to 31) and phaseWord[2:0] holds the bit within that channel (0 to 7). The captured value equals channel*8+bit, which is the number of bit clocks since the counter was last set to 0.
- R4: rxMarker passes through two synchroniser flops. If rxMarker is first sampled high at edge E1, the captured value is the counter value held between edges E1+1 and E1+2. The capture takes place at edge E1+2.
- R5: phaseValid is high for exactly one cycle after each capture edge. Each rising edge of rxMarker gives exactly one capture, however long the marker stays high.
- R6: phaseWord and frameCount hold their values between captures.
- R7: When a capture is smaller than the previous capture by more than 128 (an upward pass beyond channel 31 bit 7), frameCount toggles.
- R8: When a capture is larger than the previous capture by more than 128 (a downward pass below channel 0 bit 0), frameCount toggles.
- R9: When two successive captures differ by 128 or less, including exactly 128, frameCount does not change. The first capture after reset never toggles frameCount.
- R10: Without a framePulse, the position counter runs freely and wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local 2.048 MHz bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| framePulse | input | 1 | Local frame pulse; the counter reads 0 after the edge that samples it high |
| rxMarker | input | 1 | Asynchronous 8 kHz receive frame marker |
| phaseWord | output | 8 | Captured position: channel in bits 7:3, bit in bits 2:0 |
| frameCount | output | 1 | Ninth phase bit; toggles on each frame boundary crossing |
| phaseValid | output | 1 | One-cycle strobe after each capture |

## Verification
The embedded assertions check on every cycle that the counter restarts at 0 after a frame pulse and otherwise steps by one. They also check that the capture strobe never lasts two cycles, that phaseWord and frameCount change only alongside phaseValid, and that phaseValid is a single-cycle pulse. Some behaviour can only be shown by the bench's scenarios. These are the exact position captured after the synchroniser latency, the toggle decisions on boundary crossings in both directions, the exact 128 tie, the first capture after reset, and realignment by a frame pulse part way through a frame. In each scenario a driver places the marker at a chosen counter position and queues the expected word and ninth bit.

// File: rtl/phase_meter_pkg.sv
package phase_meter_pkg;
  localparam int CHAN_BITS = 5;
  localparam int BIT_BITS  = 3;
  localparam int POS_W     = CHAN_BITS + BIT_BITS;

  typedef struct packed {
    logic capture;   // take a snapshot of the local position
    logic rise;      // synchronised marker rising edge seen (same cycle)
  } phase_strobe_t;
endpackage

// File: rtl/phase_sync_ctrl.sv
module phase_sync_ctrl
  import phase_meter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxMarker,
  output phase_strobe_t strb
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   markerLast;
  logic                   markerSync;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncChain  <= '0;
      markerLast <= 1'b0;
    end else begin
      syncChain  <= {syncChain[SYNC_STAGES-2:0], rxMarker};
      markerLast <= markerSync;
    end
  end

  assign markerSync = syncChain[SYNC_STAGES-1];

  always_comb begin
    strb.rise    = markerSync & ~markerLast;
    strb.capture = strb.rise;
  end

  // R5: a single marker rise never yields two back-to-back captures
  p_single_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);
endmodule

// File: rtl/phase_meter_dp.sv
module phase_meter_dp
  import phase_meter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  phase_strobe_t    strb,
  output logic [POS_W-1:0] phaseWord,
  output logic             frameCount,
  output logic             phaseValid
);
  localparam logic [POS_W-1:0] HALF = POS_W'(1) << (POS_W - 1);

  logic [POS_W-1:0] bitPos;
  logic             haveRef;
  logic             crossUp;
  logic             crossDown;

  // local bus position: channel in upper bits, bit in lower bits
  always_ff @(posedge clk) begin
    if (!rstN)           bitPos <= '0;
    else if (framePulse) bitPos <= '0;
    else                 bitPos <= bitPos + POS_W'(1);
  end

  // boundary crossing by the shorter path between two captures
  always_comb begin
    crossUp   = haveRef && (phaseWord > bitPos) && ((phaseWord - bitPos) > HALF);
    crossDown = haveRef && (bitPos > phaseWord) && ((bitPos - phaseWord) > HALF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseWord  <= '0;
      frameCount <= 1'b0;
      phaseValid <= 1'b0;
      haveRef    <= 1'b0;
    end else begin
      phaseValid <= strb.capture;
      if (strb.capture) begin
        phaseWord <= bitPos;
        haveRef   <= 1'b1;
        if (crossUp || crossDown) frameCount <= ~frameCount;
      end
    end
  end

  // R2: frame pulse restarts the position at zero
  p_frame_restart_r2: assert property (@(posedge clk) disable iff (!rstN)
    framePulse |=> (bitPos == '0));
  // R10: free running step of one with natural wrap
  p_free_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!framePulse && $past(rstN)) |=> (bitPos == $past(bitPos) + POS_W'(1)));
  // R6: the phase word only moves alongside a valid strobe
  p_word_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid |-> $stable(phaseWord));
  // R6: the ninth bit only moves alongside a valid strobe
  p_count_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !phaseValid |-> $stable(frameCount));
  // R5: valid is a one-cycle pulse
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    phaseValid |=> !phaseValid);
endmodule

// File: rtl/frame_phase_meter.sv
module frame_phase_meter
  import phase_meter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             framePulse,
  input  logic             rxMarker,
  output logic [POS_W-1:0] phaseWord,
  output logic             frameCount,
  output logic             phaseValid
);
  phase_strobe_t strb;

  phase_sync_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rxMarker (rxMarker),
    .strb     (strb)
  );

  phase_meter_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .framePulse (framePulse),
    .strb       (strb),
    .phaseWord  (phaseWord),
    .frameCount (frameCount),
    .phaseValid (phaseValid)
  );
endmodule

// File: tb/tb_frame_phase_meter.sv
`timescale 1ns/1ps
module tb_frame_phase_meter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       framePulse = 1'b0;
  logic       rxMarker = 1'b0;
  logic [7:0] phaseWord;
  logic       frameCount;
  logic       phaseValid;

  int checks = 0;
  int errors = 0;
  int benchPos = 0;
  int prevCap = 0;
  bit haveRef = 0;
  bit expFc = 0;
  bit done = 0;
  int expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  frame_phase_meter dut (
    .clk(clk), .rstN(rstN), .framePulse(framePulse), .rxMarker(rxMarker),
    .phaseWord(phaseWord), .frameCount(frameCount), .phaseValid(phaseValid)
  );

  // bench model of the local position (R2, R10)
  always @(posedge clk) begin
    if (!rstN || framePulse) benchPos <= 0;
    else benchPos <= (benchPos + 1) % 256;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: raise the marker so that the capture lands on target (R4 latency)
  task automatic capture(input int target, input string req);
    int d;
    do @(negedge clk); while (benchPos != ((target + 254) % 256));
    rxMarker = 1'b1;
    d = target - prevCap;
    if (haveRef && (d > 128 || d < -128)) expFc = ~expFc;
    haveRef = 1;
    prevCap = target;
    expQ.push_back(target + (expFc ? 256 : 0));
    tagQ.push_back(req);
    repeat (7) @(negedge clk);   // held high: still one capture (R5)
    rxMarker = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: pop expected items on each valid strobe
  initial begin
    int exp;
    string tg;
    forever begin
      @(negedge clk);
      if (rstN && phaseValid) begin
        if (expQ.size() == 0) begin
          check(0, "R5 unexpected valid", 1, 0);
        end else begin
          exp = expQ.pop_front();
          tg = tagQ.pop_front();
          check(phaseWord == exp[7:0], {tg, " phase"}, phaseWord, exp % 256);
          check(frameCount == exp[8], {tg, " frameCount"}, frameCount, exp / 256);
          @(negedge clk);
          check(!phaseValid, "R5 one-cycle valid", phaseValid, 0);
          check(phaseWord == exp[7:0], "R6 word held", phaseWord, exp % 256);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phaseWord == 0 && frameCount == 0 && !phaseValid, "R1 reset state", phaseWord, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(phaseWord == 0 && frameCount == 0 && !phaseValid, "R1 idle after reset", phaseWord, 0);
    framePulse = 1'b1; @(negedge clk); framePulse = 1'b0;
    capture(200, "R9 first capture no toggle");
    capture(20, "R3 channel 2 bit 4");
    capture(140, "R9 diff 120 no toggle");
    capture(10, "R7 up crossing 130");
    capture(200, "R8 down crossing 190");
    capture(72, "R9 tie 128 no toggle");
    capture(255, "R10 last position");
    capture(0, "R7 wrap to zero");
    capture(129, "R8 down crossing 129");
    // realign mid-frame with a frame pulse (R2)
    repeat (37) @(negedge clk);
    framePulse = 1'b1; @(negedge clk); framePulse = 1'b0;
    capture(5, "R2 realigned capture");
    capture(133, "R2 after realign no toggle");
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R5 captures per marker", expQ.size(), 0);
    check(!phaseValid && frameCount == expFc, "R6 final hold", frameCount, expFc);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule